// File: doc/BRIEF.md
# Paired Translation Buffer with Register-Driven Maintenance

This block holds two small direct-mapped translation buffers, one serving instruction fetch and one serving data access, and lets privileged software keep them current through two write-only control registers. Each buffer has a combinational lookup port. The port takes a virtual address and returns a hit flag and the translated physical address. The page offset passes straight through the port.

Pages are 4 KB, so the low 12 bits of the virtual-address register carry no page number. Software uses three of those bits as control. One bit picks the buffer. Two bits carry a maintenance command: none, invalidate one entry, or flush the whole buffer. A write to the physical-address register installs an entry. The install uses the page number and buffer select that the last virtual-address write left in the register. The two register writes do not form an atomic step, so software must not let an exception fall between them. There is no way to read the buffer contents back. Software keeps the full page tables itself.

Top module: `tlb_maint`

## Requirements
- R1: After reset, every entry of both buffers is invalid, so every lookup on either port misses.
- R2: A write of `pa_wdata` with `pa_wr` installs an entry into the buffer chosen by the latched select bit. The entry sits at index `VA[15:12]` of the latched page, with tag `VA[31:16]` and physical page `pa_wdata[31:12]`. From the next cycle, a lookup of that page hits and returns `{ppn, va[11:0]}`.
- R3: A lookup hits only when the indexed entry is valid and its tag equals `va[31:16]`. On a miss, the physical-address output is zero.
- R4: Select bit 0 of the virtual-address write chooses the buffer: 0 targets the instruction buffer and 1 targets the data buffer. An install or command on one buffer never changes the other.
- R5: Command code 01 in bits [2:1] invalidates the entry at the written index, but only if its tag matches the written address. An entry with a different tag is left valid.
- R6: Command code 10 clears every entry of the selected buffer in the cycle after the write.
- R7: Command codes 00 and 11 leave the contents of both buffers unchanged.
- R8: Every virtual-address write latches its page number and select bit, whatever its command code. Later installs use these latched values.
- R9: When an install and an invalidate or flush reach the same buffer in the same cycle, the installed entry ends up valid.
- R10: The lookup ports are combinational: a change of the lookup address is reflected in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| va_wr | input | 1 | Write strobe for the virtual-address/command register |
| va_wdata | input | 32 | Page number [31:12], command [2:1], buffer select [0] |
| pa_wr | input | 1 | Write strobe for the physical-address register (triggers install) |
| pa_wdata | input | 32 | Physical page number in [31:12] |
| fetch_va | input | 32 | Instruction-side lookup address |
| fetch_hit | output | 1 | Instruction-side hit |
| fetch_pa | output | 32 | Instruction-side translated address (zero on miss) |
| load_va | input | 32 | Data-side lookup address |
| load_hit | output | 1 | Data-side hit |
| load_pa | output | 32 | Data-side translated address (zero on miss) |

## Verification
A wrong valid bit, tag or physical page shows up at the ports the first time a lookup indexes that entry, because the lookup path has no register in it. The bench therefore drives lookups at the affected page in the cycle right after each write. A latched select or page number that is wrong stays hidden until the next install, which then shows up in the wrong buffer or at the wrong index. For that reason, the cases that mix command writes with installs look up both buffers after each step. The priority when an install coincides with an invalidate or flush can only be seen by looking up the installed page in the cycle right after the coincidence.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  // Command encoding held in va register bits [2:1]
  typedef enum logic [1:0] {
    CMD_NONE  = 2'b00,
    CMD_INVAL = 2'b01,
    CMD_FLUSH = 2'b10,
    CMD_RSVD  = 2'b11
  } tlb_cmd_e;

  localparam int SEL_BIT = 0;   // buffer select position
  localparam int CMD_LSB = 1;   // command field low bit
  localparam int BUF_INST = 0;
  localparam int BUF_DATA = 1;
  localparam int NUM_BUF  = 2;
endpackage

// File: rtl/tlb_cmd_decode.sv
module tlb_cmd_decode
  import tlb_pkg::*;
#(
  parameter int VA_W      = 32,
  parameter int PA_W      = 32,
  parameter int PAGE_BITS = 12,
  localparam int VPN_W    = VA_W - PAGE_BITS,
  localparam int PPN_W    = PA_W - PAGE_BITS
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               va_wr,
  input  logic [VA_W-1:0]    va_wdata,
  input  logic               pa_wr,
  input  logic [PA_W-1:0]    pa_wdata,
  output logic [NUM_BUF-1:0] inv_req,
  output logic [NUM_BUF-1:0] flush_req,
  output logic [NUM_BUF-1:0] inst_req,
  output logic [VPN_W-1:0]   inv_vpn,
  output logic [VPN_W-1:0]   inst_vpn,
  output logic [PPN_W-1:0]   inst_ppn,
  output logic [VPN_W-1:0]   va_page_q,
  output logic               va_sel_q
);
  tlb_cmd_e cmd;
  logic     wsel;
  logic     unused_bits;

  assign cmd  = tlb_cmd_e'(va_wdata[CMD_LSB +: 2]);
  assign wsel = va_wdata[SEL_BIT];
  assign unused_bits = ^{va_wdata[PAGE_BITS-1:CMD_LSB+2], pa_wdata[PAGE_BITS-1:0]};

  // Latched page and select: every va write updates them
  always_ff @(posedge clk) begin
    if (rst) begin
      va_page_q <= '0;
      va_sel_q  <= 1'b0;
    end else if (va_wr) begin
      va_page_q <= va_wdata[VA_W-1:PAGE_BITS];
      va_sel_q  <= wsel;
    end
  end

  assign inv_vpn  = va_wdata[VA_W-1:PAGE_BITS];
  assign inst_vpn = va_page_q;
  assign inst_ppn = pa_wdata[PA_W-1:PAGE_BITS];

  for (genvar b = 0; b < NUM_BUF; b++) begin : g_req
    assign inv_req[b]   = va_wr && (cmd == CMD_INVAL) && (wsel == 1'(b));
    assign flush_req[b] = va_wr && (cmd == CMD_FLUSH) && (wsel == 1'(b));
    assign inst_req[b]  = pa_wr && (va_sel_q == 1'(b));
  end
endmodule

// File: rtl/tlb_bank.sv
module tlb_bank #(
  parameter int VA_W      = 32,
  parameter int PA_W      = 32,
  parameter int PAGE_BITS = 12,
  parameter int IDX_W     = 4,
  localparam int VPN_W    = VA_W - PAGE_BITS,
  localparam int PPN_W    = PA_W - PAGE_BITS,
  localparam int TAG_W    = VPN_W - IDX_W,
  localparam int DEPTH    = 1 << IDX_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inv_req,
  input  logic [VPN_W-1:0] inv_vpn,
  input  logic             flush_req,
  input  logic             inst_req,
  input  logic [VPN_W-1:0] inst_vpn,
  input  logic [PPN_W-1:0] inst_ppn,
  input  logic [VA_W-1:0]  lk_va,
  output logic             lk_hit,
  output logic [PA_W-1:0]  lk_pa
);
  logic [DEPTH-1:0] valid_q, valid_d;
  logic [TAG_W-1:0] tag_mem [DEPTH];
  logic [PPN_W-1:0] ppn_mem [DEPTH];

  logic [IDX_W-1:0] inv_idx, inst_idx, lk_idx;
  logic [TAG_W-1:0] inv_tag, inst_tag, lk_tag;

  assign inv_idx  = inv_vpn[IDX_W-1:0];
  assign inv_tag  = inv_vpn[VPN_W-1:IDX_W];
  assign inst_idx = inst_vpn[IDX_W-1:0];
  assign inst_tag = inst_vpn[VPN_W-1:IDX_W];
  assign lk_idx   = lk_va[PAGE_BITS +: IDX_W];
  assign lk_tag   = lk_va[VA_W-1 -: TAG_W];

  // Valid bits: flush, then matched invalidate, then install (highest priority)
  always_comb begin
    valid_d = valid_q;
    if (flush_req) valid_d = '0;
    if (inv_req && valid_q[inv_idx] && (tag_mem[inv_idx] == inv_tag))
      valid_d[inv_idx] = 1'b0;
    if (inst_req) valid_d[inst_idx] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) valid_q <= '0;
    else     valid_q <= valid_d;
  end

  // Entry storage: single write port, no reset
  always_ff @(posedge clk) begin
    if (inst_req) begin
      tag_mem[inst_idx] <= inst_tag;
      ppn_mem[inst_idx] <= inst_ppn;
    end
  end

  // Combinational lookup
  assign lk_hit = valid_q[lk_idx] && (tag_mem[lk_idx] == lk_tag);
  assign lk_pa  = lk_hit ? {ppn_mem[lk_idx], lk_va[PAGE_BITS-1:0]} : '0;
endmodule

// File: rtl/tlb_maint.sv
module tlb_maint
  import tlb_pkg::*;
#(
  parameter int VA_W      = 32,
  parameter int PA_W      = 32,
  parameter int PAGE_BITS = 12,
  parameter int IDX_W     = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            va_wr,
  input  logic [VA_W-1:0] va_wdata,
  input  logic            pa_wr,
  input  logic [PA_W-1:0] pa_wdata,
  input  logic [VA_W-1:0] fetch_va,
  output logic            fetch_hit,
  output logic [PA_W-1:0] fetch_pa,
  input  logic [VA_W-1:0] load_va,
  output logic            load_hit,
  output logic [PA_W-1:0] load_pa
);
  localparam int VPN_W = VA_W - PAGE_BITS;
  localparam int PPN_W = PA_W - PAGE_BITS;

  logic [NUM_BUF-1:0] inv_req, flush_req, inst_req;
  logic [VPN_W-1:0]   inv_vpn, inst_vpn, va_page_q;
  logic [PPN_W-1:0]   inst_ppn;
  logic               va_sel_q;

  logic [VA_W-1:0] lk_va  [NUM_BUF];
  logic            lk_hit [NUM_BUF];
  logic [PA_W-1:0] lk_pa  [NUM_BUF];

  tlb_cmd_decode #(.VA_W(VA_W), .PA_W(PA_W), .PAGE_BITS(PAGE_BITS)) i_dec (
    .clk(clk), .rst(rst), .va_wr(va_wr), .va_wdata(va_wdata),
    .pa_wr(pa_wr), .pa_wdata(pa_wdata),
    .inv_req(inv_req), .flush_req(flush_req), .inst_req(inst_req),
    .inv_vpn(inv_vpn), .inst_vpn(inst_vpn), .inst_ppn(inst_ppn),
    .va_page_q(va_page_q), .va_sel_q(va_sel_q)
  );

  assign lk_va[BUF_INST] = fetch_va;
  assign lk_va[BUF_DATA] = load_va;

  for (genvar b = 0; b < NUM_BUF; b++) begin : g_buf
    tlb_bank #(.VA_W(VA_W), .PA_W(PA_W), .PAGE_BITS(PAGE_BITS), .IDX_W(IDX_W)) i_bank (
      .clk(clk), .rst(rst),
      .inv_req(inv_req[b]), .inv_vpn(inv_vpn), .flush_req(flush_req[b]),
      .inst_req(inst_req[b]), .inst_vpn(inst_vpn), .inst_ppn(inst_ppn),
      .lk_va(lk_va[b]), .lk_hit(lk_hit[b]), .lk_pa(lk_pa[b])
    );
  end

  assign fetch_hit = lk_hit[BUF_INST];
  assign fetch_pa  = lk_pa[BUF_INST];
  assign load_hit  = lk_hit[BUF_DATA];
  assign load_pa   = lk_pa[BUF_DATA];
endmodule

// File: rtl/tlb_maint_chk.sv
module tlb_maint_chk #(
  parameter int VA_W      = 32,
  parameter int PA_W      = 32,
  parameter int PAGE_BITS = 12
) (
  input logic                      clk,
  input logic                      rst,
  input logic                      va_wr,
  input logic [VA_W-1:0]           va_wdata,
  input logic                      pa_wr,
  input logic [PA_W-1:0]           pa_wdata,
  input logic [VA_W-1:0]           fetch_va,
  input logic                      fetch_hit,
  input logic [PA_W-1:0]           fetch_pa,
  input logic [VA_W-1:0]           load_va,
  input logic                      load_hit,
  input logic [PA_W-1:0]           load_pa,
  input logic [VA_W-PAGE_BITS-1:0] va_page_q,
  input logic                      va_sel_q
);
  // R1: the cycle after reset, nothing hits
  p_reset_miss_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!fetch_hit && !load_hit));

  // R2: install of the instruction side hits on the installed page next cycle
  p_install_hit_r2: assert property (@(posedge clk) disable iff (rst)
    ($past(pa_wr && !rst && !va_sel_q) &&
     fetch_va[VA_W-1:PAGE_BITS] == $past(va_page_q))
    |-> (fetch_hit && fetch_pa[PA_W-1:PAGE_BITS] == $past(pa_wdata[PA_W-1:PAGE_BITS])));

  // R3: offset passes through on a hit, zero output on a miss
  p_offset_r3: assert property (@(posedge clk) disable iff (rst)
    fetch_hit |-> (fetch_pa[PAGE_BITS-1:0] == fetch_va[PAGE_BITS-1:0]));
  p_miss_zero_r3: assert property (@(posedge clk) disable iff (rst)
    !load_hit |-> (load_pa == '0));

  // R6: flush without a concurrent install empties the selected buffer
  p_flush_inst_r6: assert property (@(posedge clk) disable iff (rst)
    $past(!rst && va_wr && va_wdata[2:1] == 2'b10 && !va_wdata[0] && !pa_wr) |-> !fetch_hit);
  p_flush_data_r6: assert property (@(posedge clk) disable iff (rst)
    $past(!rst && va_wr && va_wdata[2:1] == 2'b10 && va_wdata[0] && !pa_wr) |-> !load_hit);
endmodule

bind tlb_maint tlb_maint_chk #(.VA_W(VA_W), .PA_W(PA_W), .PAGE_BITS(PAGE_BITS)) i_chk (
  .clk(clk), .rst(rst), .va_wr(va_wr), .va_wdata(va_wdata),
  .pa_wr(pa_wr), .pa_wdata(pa_wdata),
  .fetch_va(fetch_va), .fetch_hit(fetch_hit), .fetch_pa(fetch_pa),
  .load_va(load_va), .load_hit(load_hit), .load_pa(load_pa),
  .va_page_q(va_page_q), .va_sel_q(va_sel_q)
);

// File: tb/test_tlb_maint.sv
`timescale 1ns/1ps
module test_tlb_maint;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        va_wr = 1'b0, pa_wr = 1'b0;
  logic [31:0] va_wdata = '0, pa_wdata = '0;
  logic [31:0] fetch_va = '0, load_va = '0;
  logic        fetch_hit, load_hit;
  logic [31:0] fetch_pa, load_pa;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  tlb_maint i_tlb_maint (
    .clk(clk), .rst(rst), .va_wr(va_wr), .va_wdata(va_wdata),
    .pa_wr(pa_wr), .pa_wdata(pa_wdata),
    .fetch_va(fetch_va), .fetch_hit(fetch_hit), .fetch_pa(fetch_pa),
    .load_va(load_va), .load_hit(load_hit), .load_pa(load_pa)
  );

  // Behavioural reference: per-buffer page maps
  bit          m_val [2][16];
  logic [15:0] m_tag [2][16];
  logic [19:0] m_ppn [2][16];
  logic [19:0] m_page;
  bit          m_sel;

  always @(posedge clk) begin
    if (rst) begin
      foreach (m_val[b, i]) m_val[b][i] = 1'b0;
      m_page = '0; m_sel = 1'b0;
    end else begin
      if (va_wr) begin
        int s, x;
        s = int'(va_wdata[0]); x = int'(va_wdata[15:12]);
        if (va_wdata[2:1] == 2'b01 && m_val[s][x] && m_tag[s][x] == va_wdata[31:16])
          m_val[s][x] = 1'b0;
        if (va_wdata[2:1] == 2'b10)
          for (int i = 0; i < 16; i++) m_val[s][i] = 1'b0;
      end
      if (pa_wr) begin
        int s, x;
        s = int'(m_sel); x = int'(m_page[3:0]);
        m_val[s][x] = 1'b1; m_tag[s][x] = m_page[19:4]; m_ppn[s][x] = pa_wdata[31:12];
      end
      if (va_wr) begin
        m_page = va_wdata[31:12]; m_sel = va_wdata[0];
      end
    end
  end

  function automatic logic [32:0] model_look(int s, logic [31:0] a);
    int x = int'(a[15:12]);
    if (m_val[s][x] && m_tag[s][x] == a[31:16]) return {1'b1, m_ppn[s][x], a[11:0]};
    return 33'd0;
  endfunction

  // Every-cycle comparison against the model (R10: same-cycle lookup)
  always @(negedge clk) begin
    if (!rst && !done) begin
      logic [32:0] ef, el;
      ef = model_look(0, fetch_va); el = model_look(1, load_va);
      checks++;
      if ({fetch_hit, fetch_pa} !== ef) begin
        fails++;
        $display("FAIL R10 model fetch: actual %b/%h expected %b/%h", fetch_hit, fetch_pa, ef[32], ef[31:0]);
      end
      checks++;
      if ({load_hit, load_pa} !== el) begin
        fails++;
        $display("FAIL R10 model load: actual %b/%h expected %b/%h", load_hit, load_pa, el[32], el[31:0]);
      end
    end
  end

  task automatic cyc();
    @(posedge clk); #3;
  endtask

  task automatic wr_va(logic [31:0] d);
    cyc(); va_wr = 1'b1; va_wdata = d;
    cyc(); va_wr = 1'b0;
  endtask

  task automatic wr_pa(logic [31:0] d);
    cyc(); pa_wr = 1'b1; pa_wdata = d;
    cyc(); pa_wr = 1'b0;
  endtask

  // Directed lookup: set address, sample at the following negedge
  task automatic look(string req, bit side, logic [31:0] a, bit eh, logic [31:0] ep);
    if (side) load_va = a; else fetch_va = a;
    #7;
    checks++;
    if (side ? ({load_hit, load_pa} !== {eh, ep}) : ({fetch_hit, fetch_pa} !== {eh, ep})) begin
      fails++;
      $display("FAIL %s %s va=%h: actual %b/%h expected %b/%h", req, side ? "load" : "fetch", a,
               side ? load_hit : fetch_hit, side ? load_pa : fetch_pa, eh, ep);
    end
    #1;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #3 rst = 1'b0;
    // R1: empty after reset
    look("R1", 0, 32'h1234_5678, 0, 0);
    look("R1", 1, 32'h1234_5678, 0, 0);
    // R2/R4: install instruction entry (select 0)
    wr_va(32'h0004_5000);
    wr_pa(32'hABCD_E000);
    look("R2", 0, 32'h0004_5ABC, 1, 32'hABCD_EABC);
    look("R4", 1, 32'h0004_5ABC, 0, 0);
    // R3: same index, other tag
    look("R3", 0, 32'h0014_5ABC, 0, 0);
    // R4: data entry (select 1)
    wr_va(32'h0004_7001);
    wr_pa(32'h1111_1000);
    look("R4", 1, 32'h0004_7123, 1, 32'h1111_1123);
    look("R4", 0, 32'h0004_7123, 0, 0);
    // R7: reserved and no-op codes
    wr_va(32'h0004_5006);
    look("R7", 0, 32'h0004_5ABC, 1, 32'hABCD_EABC);
    wr_va(32'h0004_7001);
    look("R7", 1, 32'h0004_7123, 1, 32'h1111_1123);
    // R5: tag-mismatch invalidate keeps entry, matching one clears it
    wr_va(32'h0014_5002);
    look("R5", 0, 32'h0004_5ABC, 1, 32'hABCD_EABC);
    wr_va(32'h0004_5002);
    look("R5", 0, 32'h0004_5ABC, 0, 0);
    look("R5", 1, 32'h0004_7123, 1, 32'h1111_1123);
    // R8: the invalidate write latched page 0x00045 select 0
    wr_pa(32'h2222_2000);
    look("R8", 0, 32'h0004_5ABC, 1, 32'h2222_2ABC);
    // R6: flush data only, then instruction
    wr_va(32'h0003_3000);
    wr_pa(32'h3333_3000);
    wr_va(32'h0000_0005);
    look("R6", 1, 32'h0004_7123, 0, 0);
    look("R6", 0, 32'h0003_3444, 1, 32'h3333_3444);
    wr_va(32'h0000_0004);
    look("R6", 0, 32'h0003_3444, 0, 0);
    look("R6", 0, 32'h0004_5ABC, 0, 0);
    // R9: install coinciding with invalidate of the same entry
    wr_va(32'h0008_8000);
    cyc(); va_wr = 1'b1; va_wdata = 32'h0008_8002; pa_wr = 1'b1; pa_wdata = 32'h4444_4000;
    cyc(); va_wr = 1'b0; pa_wr = 1'b0;
    look("R9", 0, 32'h0008_8010, 1, 32'h4444_4010);
    // R9: install coinciding with flush of the same buffer
    wr_va(32'h0002_2000);
    wr_pa(32'h6666_6000);
    wr_va(32'h0008_8000);
    cyc(); va_wr = 1'b1; va_wdata = 32'h0000_0004; pa_wr = 1'b1; pa_wdata = 32'h5555_5000;
    cyc(); va_wr = 1'b0; pa_wr = 1'b0;
    look("R9", 0, 32'h0008_8FFF, 1, 32'h5555_5FFF);
    look("R9", 0, 32'h0002_2000, 0, 0);
    // R10: address change seen without a clock edge
    wr_va(32'h0009_9001);
    wr_pa(32'h7777_7000);
    load_va = 32'h0009_9001; #1;
    checks++;
    if (!load_hit || load_pa !== 32'h7777_7001) begin
      fails++; $display("FAIL R10 comb: actual %b/%h expected 1/77777001", load_hit, load_pa);
    end
    load_va = 32'h0009_8001; #1;
    checks++;
    if (load_hit || load_pa !== 32'h0) begin
      fails++; $display("FAIL R10 comb: actual %b/%h expected 0/00000000", load_hit, load_pa);
    end
    cyc();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    done = 1'b1;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule